// File: doc/BRIEF.md
# Cumulative-Boundary Raster Timing Generator

This block produces the raster timing for a parallel RGB display panel: a horizontal sync, a vertical sync and a data-enable window, each with a selectable active level. Software does not give it separate porch lengths. Instead it gives running boundaries along each axis. The first is the sync width minus one. The back-porch boundary adds the back porch to that. The active boundary adds the active size, and the total adds the front porch. The generator compares two free-running counters against these boundaries.

All configuration comes in on plain input ports that a register block elsewhere has already latched. Each 32-bit boundary word carries the horizontal value in bits [27:16] and the vertical value in bits [10:0]. The block reports the current counter position. It raises a one-cycle line-event pulse on a programmed line and a one-cycle strobe at the first blanking line after the active area. It also passes on the launch-edge selection for the pixel data. There is no data stream through the block, so it has no valid/ready handshake. Every pin is a plain control or status level.

Top module: `raster_timing_gen`

## Requirements
- R1: Each boundary word is decoded with the horizontal value taken from bits [27:16] and the vertical value taken from bits [10:0]. All other bits of the word have no effect on any output.
- R2: While running, the horizontal position counts 0,1,… up to the total-width value inclusive and then returns to 0. The vertical position advances by one at each such return and goes back to 0 after the total-height value.
- R3: Horizontal sync is active while the horizontal position is less than or equal to the horizontal sync field. Vertical sync is active while the vertical position is less than or equal to the vertical sync field.
- R4: Data enable is active when the horizontal position is greater than the horizontal back-porch boundary and not greater than the horizontal active boundary, and the vertical position meets the same test against the vertical boundaries.
- R5: Each of the three polarity inputs works the same way for its own signal. A value of 0 drives that signal low when active and high when inactive. A value of 1 drives it high when active and low when inactive.
- R6: While the enable input is 0, and in the first cycle after it rises, the position outputs are 0, sync and data enable sit at their inactive levels, and both pulse outputs and the launch-edge output are 0. After that first cycle, counting starts from position (0,0).
- R7: The line-event output is 1 for exactly the cycle in which the horizontal position is 0 and the vertical position equals the line-position input.
- R8: The blanking strobe is 1 for the cycle in which the horizontal position is 0 and the vertical position equals the vertical active boundary plus one. If that boundary equals the total height, the strobe never fires.
- R9: The launch-edge output equals the clock-inversion input while running and is 0 otherwise.
- R10: The position outputs always show the current horizontal and vertical counter values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_enable | input | 1 | Global run enable |
| cfg_hs_pol | input | 1 | 1: horizontal sync active high |
| cfg_vs_pol | input | 1 | 1: vertical sync active high |
| cfg_de_pol | input | 1 | 1: data enable active high |
| cfg_clk_inv | input | 1 | Launch data on the opposite clock edge |
| cfg_sync | input | 32 | Sync widths minus one (H in [27:16], V in [10:0]) |
| cfg_bporch | input | 32 | Back-porch boundaries |
| cfg_active | input | 32 | Active-area boundaries |
| cfg_total | input | 32 | Total line width and frame height, minus one |
| cfg_line_pos | input | 11 | Line that raises the line event |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Data enable |
| pclk_inv_o | output | 1 | Launch-edge select to the output stage |
| line_evt_o | output | 1 | Line-event pulse |
| vblank_o | output | 1 | Start-of-blanking strobe |
| pos_x_o | output | 12 | Current horizontal position |
| pos_y_o | output | 11 | Current vertical position |

## Verification
The bench uses the default field widths and bit positions, 12 bits horizontal at offset 16 and 11 bits vertical at offset 0, and fills the unused bits of every word with non-zero patterns. The raster is kept very small: a 10-pixel by 7-line frame and a 1-pixel-wide frame. This makes every wrap, sync edge, window edge and pulse occur within a few hundred cycles. It also reaches the degenerate cases: a zero total width, an empty data-enable window, and an active boundary equal to the total height, where the blanking strobe must stay silent.

// File: rtl/raster_pkg.sv
package raster_pkg;

  // Per-axis comparison results for one counter value.
  typedef struct packed {
    logic sync;   // counter inside the sync pulse
    logic win;    // counter inside the active window
    logic zero;   // counter at its first position
  } axis_flags_t;

  // Drive level for a signal given its activity and its polarity bit.
  function automatic logic drive_level(input logic active, input logic act_high);
    return act_high ? active : ~active;
  endfunction

endpackage

// File: rtl/rt_axis_counter.sv
module rt_axis_counter #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         step,
  input  logic [W-1:0] limit,
  output logic [W-1:0] count,
  output logic         wrap
);

  always_ff @(posedge clk) begin
    if (!rst_n)           count <= '0;
    else if (clear)       count <= '0;
    else if (step) begin
      if (count == limit) count <= '0;
      else                count <= count + 1'b1;
    end
  end

  assign wrap = step && (count == limit);

  // R2: a step at the limit brings the counter back to zero
  p_wrap_zero_r2: assert property (@(posedge clk) disable iff (!rst_n || clear)
    (step && count == limit) |=> (count == '0));

  // R2: a step below the limit advances by exactly one
  p_step_one_r2: assert property (@(posedge clk) disable iff (!rst_n || clear)
    (step && count != limit) |=> (count == $past(count) + 1'b1));

endmodule

// File: rtl/rt_axis_decode.sv
module rt_axis_decode
  import raster_pkg::*;
#(
  parameter int W = 12
) (
  input  logic [W-1:0] count,
  input  logic [W-1:0] sync_f,
  input  logic [W-1:0] bp_edge,
  input  logic [W-1:0] act_edge,
  output axis_flags_t  flags
);

  always_comb begin
    flags.sync = (count <= sync_f);
    flags.win  = (count > bp_edge) && (count <= act_edge);
    flags.zero = (count == '0);
  end

endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import raster_pkg::*;
#(
  parameter int CFG_W = 32,
  parameter int HW    = 12,
  parameter int H_LSB = 16,
  parameter int VW    = 11,
  parameter int V_LSB = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_enable,
  input  logic             cfg_hs_pol,
  input  logic             cfg_vs_pol,
  input  logic             cfg_de_pol,
  input  logic             cfg_clk_inv,
  input  logic [CFG_W-1:0] cfg_sync,
  input  logic [CFG_W-1:0] cfg_bporch,
  input  logic [CFG_W-1:0] cfg_active,
  input  logic [CFG_W-1:0] cfg_total,
  input  logic [VW-1:0]    cfg_line_pos,
  output logic             hsync_o,
  output logic             vsync_o,
  output logic             de_o,
  output logic             pclk_inv_o,
  output logic             line_evt_o,
  output logic             vblank_o,
  output logic [HW-1:0]    pos_x_o,
  output logic [VW-1:0]    pos_y_o
);

  localparam int H_MSB = H_LSB + HW - 1;
  localparam int V_MSB = V_LSB + VW - 1;
  localparam logic [CFG_W-1:0] FIELD_MASK =
      ({{(CFG_W-HW){1'b0}}, {HW{1'b1}}} << H_LSB) |
      ({{(CFG_W-VW){1'b0}}, {VW{1'b1}}} << V_LSB);

  // Field extraction
  logic [HW-1:0] h_sync_f, h_bp, h_act, h_tot;
  logic [VW-1:0] v_sync_f, v_bp, v_act, v_tot;

  assign h_sync_f = cfg_sync[H_MSB:H_LSB];
  assign h_bp     = cfg_bporch[H_MSB:H_LSB];
  assign h_act    = cfg_active[H_MSB:H_LSB];
  assign h_tot    = cfg_total[H_MSB:H_LSB];
  assign v_sync_f = cfg_sync[V_MSB:V_LSB];
  assign v_bp     = cfg_bporch[V_MSB:V_LSB];
  assign v_act    = cfg_active[V_MSB:V_LSB];
  assign v_tot    = cfg_total[V_MSB:V_LSB];

  logic spare_bits_unused;
  assign spare_bits_unused = ^{cfg_sync & ~FIELD_MASK, cfg_bporch & ~FIELD_MASK,
                               cfg_active & ~FIELD_MASK, cfg_total & ~FIELD_MASK};

  // Run state: one cycle of settling after enable rises
  logic run_q;
  always_ff @(posedge clk) begin
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= cfg_enable;
  end

  // Counters
  logic [HW-1:0] hcnt;
  logic [VW-1:0] vcnt;
  logic          h_wrap, v_wrap_unused;

  rt_axis_counter #(.W(HW)) u_hcnt (
    .clk(clk), .rst_n(rst_n), .clear(!cfg_enable), .step(run_q),
    .limit(h_tot), .count(hcnt), .wrap(h_wrap)
  );

  rt_axis_counter #(.W(VW)) u_vcnt (
    .clk(clk), .rst_n(rst_n), .clear(!cfg_enable), .step(h_wrap),
    .limit(v_tot), .count(vcnt), .wrap(v_wrap_unused)
  );

  // Boundary decode
  axis_flags_t hf, vf;

  rt_axis_decode #(.W(HW)) u_hdec (
    .count(hcnt), .sync_f(h_sync_f), .bp_edge(h_bp), .act_edge(h_act), .flags(hf)
  );

  rt_axis_decode #(.W(VW)) u_vdec (
    .count(vcnt), .sync_f(v_sync_f), .bp_edge(v_bp), .act_edge(v_act), .flags(vf)
  );

  logic hs_act, vs_act, de_act;
  assign hs_act = run_q && hf.sync;
  assign vs_act = run_q && vf.sync;
  assign de_act = run_q && hf.win && vf.win;

  assign hsync_o    = drive_level(hs_act, cfg_hs_pol);
  assign vsync_o    = drive_level(vs_act, cfg_vs_pol);
  assign de_o       = drive_level(de_act, cfg_de_pol);
  assign pclk_inv_o = run_q && cfg_clk_inv;

  assign line_evt_o = run_q && hf.zero && (vcnt == cfg_line_pos);
  assign vblank_o   = run_q && hf.zero &&
                      ({1'b0, vcnt} == ({1'b0, v_act} + 1'b1));

  assign pos_x_o = hcnt;
  assign pos_y_o = vcnt;

  // R6: while not running every output sits idle
  p_idle_outputs_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> (de_o == !cfg_de_pol) && (hsync_o == !cfg_hs_pol) &&
               !line_evt_o && !vblank_o && !pclk_inv_o && pos_x_o == '0);

  // R7: the line event lasts one cycle when lines are wider than one pixel
  p_line_single_r7: assert property (@(posedge clk) disable iff (!rst_n || !cfg_enable)
    (line_evt_o && h_tot != '0) |=> !line_evt_o);

  // R8: the blanking strobe never coincides with the data window
  p_vblank_no_de_r8: assert property (@(posedge clk) disable iff (!rst_n)
    vblank_o |-> !de_act);

endmodule

// File: tb/test_raster_timing_gen.sv
`timescale 1ns/1ps
module test_raster_timing_gen;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0, hpol = 1'b0, vpol = 1'b0, dpol = 1'b0, cinv = 1'b0;
  logic [31:0] w_sync, w_bp, w_act, w_tot;
  logic [10:0] line_pos = '0;
  logic        hs, vs, de, pinv, lev, vbl;
  logic [11:0] px;
  logic [10:0] py;

  always #2.5 clk = ~clk;

  // Raw field values the bench reasons about
  int hsf, hbp, hac, htt, vsf, vbp, vac, vtt;

  raster_timing_gen i_raster_timing_gen (
    .clk(clk), .rst_n(rst_n), .cfg_enable(en),
    .cfg_hs_pol(hpol), .cfg_vs_pol(vpol), .cfg_de_pol(dpol), .cfg_clk_inv(cinv),
    .cfg_sync(w_sync), .cfg_bporch(w_bp), .cfg_active(w_act), .cfg_total(w_tot),
    .cfg_line_pos(line_pos),
    .hsync_o(hs), .vsync_o(vs), .de_o(de), .pclk_inv_o(pinv),
    .line_evt_o(lev), .vblank_o(vbl), .pos_x_o(px), .pos_y_o(py)
  );

  int checks = 0, fails = 0;
  bit started = 0, done = 0;

  function automatic logic [31:0] pack_word(int h, int v, logic [3:0] junk);
    return {junk, h[11:0], junk[0], 4'b1010, v[10:0]};
  endfunction

  task automatic load_cfg(int a_hsf, int a_hbp, int a_hac, int a_htt,
                          int a_vsf, int a_vbp, int a_vac, int a_vtt);
    hsf = a_hsf; hbp = a_hbp; hac = a_hac; htt = a_htt;
    vsf = a_vsf; vbp = a_vbp; vac = a_vac; vtt = a_vtt;
    w_sync = pack_word(hsf, vsf, 4'hA);   // R1: junk outside the fields
    w_bp   = pack_word(hbp, vbp, 4'h5);
    w_act  = pack_word(hac, vac, 4'hF);
    w_tot  = pack_word(htt, vtt, 4'h3);
  endtask

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
    end
  endtask

  // Behavioural reference: position and run state
  int  hm = 0, vm = 0;
  bit  runm = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      hm <= 0; vm <= 0; runm <= 0;
    end else begin
      runm <= en;
      if (!en) begin
        hm <= 0; vm <= 0;
      end else if (runm) begin
        if (hm == htt) begin
          hm <= 0;
          vm <= (vm == vtt) ? 0 : vm + 1;
        end else hm <= hm + 1;
      end
    end
  end

  // Compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (started && !done) begin
      bit hs_a, vs_a, de_a, lev_e, vbl_e;
      hs_a  = runm && (hm <= hsf);
      vs_a  = runm && (vm <= vsf);
      de_a  = runm && (hm > hbp) && (hm <= hac) && (vm > vbp) && (vm <= vac);
      lev_e = runm && (hm == 0) && (vm == int'(line_pos));
      vbl_e = runm && (hm == 0) && (vm == vac + 1);
      if (!runm) begin
        chk("R6 pos_x", px, 0);
        chk("R6 pos_y", py, 0);
        chk("R6 hsync idle", hs, !hpol);
        chk("R6 vsync idle", vs, !vpol);
        chk("R6 de idle", de, !dpol);
        chk("R6 pulses idle", {lev, vbl, pinv}, 0);
      end else begin
        chk("R2 R10 pos_x", px, hm);
        chk("R2 R10 pos_y", py, vm);
        chk("R3 R5 hsync", hs, hpol ? hs_a : !hs_a);
        chk("R3 R5 vsync", vs, vpol ? vs_a : !vs_a);
        chk("R4 R1 de", de, dpol ? de_a : !de_a);
        chk("R7 line event", lev, lev_e);
        chk("R8 vblank strobe", vbl, vbl_e);
        chk("R9 launch edge", pinv, cinv);
      end
    end
  end

  task automatic wait_cycles(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
    end
  end

  int pulses;
  initial begin
    load_cfg(1, 3, 7, 9, 0, 2, 5, 6);     // 10 x 7 raster
    wait_cycles(3);
    started = 1;
    wait_cycles(3);
    rst_n = 1'b1;                         // R6: reset state checked while idle
    wait_cycles(4);
    line_pos = 11'd6;
    en = 1'b1;                            // R6: first cycle after enable stays at (0,0)
    wait_cycles(1);
    chk("R6 first enabled cycle pos_x", px, 0);
    wait_cycles(1);
    chk("R6 counting begins pos_x", px, 1);
    wait_cycles(3 * 70);
    hpol = 1; vpol = 1; dpol = 1; cinv = 1; line_pos = 11'd3;   // R5, R9
    pulses = 0;
    for (int i = 0; i < 140; i++) begin
      wait_cycles(1);
      if (lev) pulses++;
    end
    chk("R7 line events in two frames", pulses, 2);
    wait_cycles(17);
    en = 1'b0;                            // R6: disable mid-frame
    wait_cycles(10);
    load_cfg(0, 0, 0, 0, 1, 1, 4, 4);     // one pixel per line, vblank never fires (R8)
    hpol = 0; dpol = 0; line_pos = 11'd2;
    en = 1'b1;
    wait_cycles(40);
    en = 1'b0;
    wait_cycles(5);
    load_cfg(2, 4, 9, 12, 1, 1, 3, 5);    // R1, R4: different geometry
    vpol = 0; cinv = 0; line_pos = 11'd0;
    en = 1'b1;
    wait_cycles(2 * 13 * 6 + 7);
    finish_run();
  end

endmodule